// File: doc/BRIEF.md
# SPI Flash Memory Window Bridge

The bridge lets a processor reach serial flash devices through plain loads and stores. A load or store of one to four bytes to the window of a selected slave becomes the same number of byte exchanges on a mode 0 SPI bus. Bytes go out least significant first, and each byte is shifted most significant bit first. The requester is held off until every byte has moved. A load then returns the bytes that came back, packed little-endian.

A small register file sets what the window does. Each slave has a control word: its two low bits pick a command mode, and only user mode lets window traffic reach the bus. Bit 2 of the same word directly drives that slave's active-low select pin. A shared configuration word holds one store-enable bit per slave. A store is dropped when the mode is not user mode or the enable is clear. A load in a non-user mode returns all ones and produces no bus activity. Software frames a flash command by itself: it clears the stop bit, issues window accesses, and sets the bit again.

Top module: `spi_win_bridge`

## Requirements
- R1: After reset every `spi_cs_n` bit is 1, every slave control word (word address 4+n) reads 0x0000_0004, the configuration word (address 0) reads 0, and the status word (address 2) reads 0x0000_0800 (bit 11, transfer-done).
- R2: `spi_cs_n[n]` equals bit 2 of control word n from the clock edge that stores a write to that word. Each slave's pin is independent of the others and of window traffic.
- R3: Bits [1:0] of a control word hold the command mode (0 read, 1 fast read, 2 write, 3 user). All 32 bits of control and configuration words read back as written.
- R4: Configuration bit 16+n enables stores to slave n. A store to a slave whose bit is 0 returns ready with no SCK edges.
- R5: An access of N bytes (`mem_len` = N-1) produces exactly 8*N SCK rising edges. Bytes go lowest first, MSB first, in SPI mode 0 (SCK idles low, data is sampled on rising edges). Every SCK high phase lasts CLK_DIV clock cycles.
- R6: During a window load, MOSI carries 0x00 for every byte. Received byte i lands at `mem_rdata[8i+7:8i]`, and bytes above N read as 0.
- R7: When the target slave is not in user mode, a load returns 0xFFFF_FFFF and a store is discarded, both with no SCK edges.
- R8: `mem_ready` is a single-cycle pulse raised only after all byte transfers of the access are complete. `mem_rdata` is valid in that cycle.
- R9: A store sends byte i of `mem_wdata` as the i-th byte on MOSI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | ADDR_W | register word address |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data, combinational from reg_addr |
| mem_req | input | 1 | window access request, held until mem_ready |
| mem_we | input | 1 | 1 = store, 0 = load |
| mem_sel | input | CS_W | target slave |
| mem_len | input | 2 | access size in bytes minus one |
| mem_wdata | input | 32 | store data, little-endian |
| mem_rdata | output | 32 | load data, valid with mem_ready |
| mem_ready | output | 1 | access complete pulse |
| spi_sck | output | 1 | serial clock |
| spi_mosi | output | 1 | serial data out |
| spi_miso | input | 1 | serial data in |
| spi_cs_n | output | NUM_CS | active-low slave selects |

## Verification
The bench checks the three gates that block traffic: a non-user mode on a load, a non-user mode on a store, and a clear store-enable bit. A design that leaks a gated access shows SCK edges and a slave byte count that moves. A design that returns zeros instead of ones on a blocked load fails the data compare. Accesses of one, two, three and four bytes expose a byte order that is reversed or shifted by one, and upper bytes that are not cleared. Select pins are toggled while accesses run on another slave, which catches designs that tie the pins to transaction framing or update the wrong slave.

// File: rtl/spiw_pkg.sv
package spiw_pkg;
   typedef enum logic [1:0] {
      MODE_READ  = 2'd0,
      MODE_FREAD = 2'd1,
      MODE_WRITE = 2'd2,
      MODE_USER  = 2'd3
   } cmd_mode_e;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_LAUNCH = 2'd1,
      SQ_WAIT   = 2'd2,
      SQ_DONE   = 2'd3
   } seq_state_e;

   localparam int          STOP_BIT     = 2;
   localparam int          WEN_BASE     = 16;
   localparam int          CFG_ADDR     = 0;
   localparam int          STAT_ADDR    = 2;
   localparam int          CTRL_BASE    = 4;
   localparam logic [31:0] STAT_RESET   = 32'h0000_0800;
   localparam logic [31:0] CTRL_RESET   = 32'h0000_0004;
endpackage

// File: rtl/spiw_regs.sv
module spiw_regs
   import spiw_pkg::*;
#(
   parameter int NUM_CS = 2,
   parameter int ADDR_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [31:0]            wdata,
   output logic [31:0]            rdata,
   output logic [NUM_CS-1:0]      wen,
   output logic [NUM_CS-1:0][1:0] mode,
   output logic [NUM_CS-1:0]      cs_n
);
   logic [31:0]              cfg_q;
   logic [NUM_CS-1:0][31:0]  ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (we && addr == ADDR_W'(CFG_ADDR))
         cfg_q <= wdata;
   end

   for (genvar n = 0; n < NUM_CS; n++) begin : g_cs
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CTRL_BASE + n);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ctrl_q[n] <= CTRL_RESET;
         else if (we && addr == MY_ADDR)
            ctrl_q[n] <= wdata;
      end

      assign cs_n[n] = ctrl_q[n][STOP_BIT];
      assign mode[n] = ctrl_q[n][1:0];
      assign wen[n]  = cfg_q[WEN_BASE + n];

      // R2
      cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (we && addr == MY_ADDR) |=> (cs_n[n] == $past(wdata[STOP_BIT])));
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(CFG_ADDR))  rdata = cfg_q;
      if (addr == ADDR_W'(STAT_ADDR)) rdata = STAT_RESET;
      for (int n = 0; n < NUM_CS; n++)
         if (addr == ADDR_W'(CTRL_BASE + n)) rdata = ctrl_q[n];
   end
endmodule

// File: rtl/spiw_shift.sv
module spiw_shift #(
   parameter int CLK_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx_byte,
   output logic [7:0] rx_byte,
   output logic       done,
   output logic       busy,
   output logic       sck,
   output logic       mosi,
   input  logic       miso
);
   localparam int DW = $clog2(CLK_DIV + 1);
   localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

   logic [DW-1:0] div_q;
   logic [2:0]    bit_q;
   logic [7:0]    sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= '0;
         bit_q   <= '0;
         sh_q    <= '0;
         rx_byte <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
         sck     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            sh_q  <= tx_byte;
            busy  <= 1'b1;
            bit_q <= '0;
            div_q <= '0;
            sck   <= 1'b0;
         end else if (busy) begin
            if (div_q == DIV_LAST) begin
               div_q <= '0;
               if (!sck) begin
                  sck     <= 1'b1;
                  rx_byte <= {rx_byte[6:0], miso};
               end else begin
                  sck  <= 1'b0;
                  sh_q <= {sh_q[6:0], 1'b0};
                  if (bit_q == 3'd7) begin
                     busy <= 1'b0;
                     done <= 1'b1;
                  end else begin
                     bit_q <= bit_q + 3'd1;
                  end
               end
            end else begin
               div_q <= div_q + DW'(1);
            end
         end
      end
   end

   assign mosi = sh_q[7];

   // R5
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   // R5
   sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !sck);
endmodule

// File: rtl/spiw_seq.sv
module spiw_seq
   import spiw_pkg::*;
#(
   parameter int NUM_CS = 2,
   parameter int CS_W   = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   mem_req,
   input  logic                   mem_we,
   input  logic [CS_W-1:0]        mem_sel,
   input  logic [1:0]             mem_len,
   input  logic [31:0]            mem_wdata,
   output logic [31:0]            mem_rdata,
   output logic                   mem_ready,
   input  logic [NUM_CS-1:0]      wen,
   input  logic [NUM_CS-1:0][1:0] mode,
   output logic                   sh_start,
   output logic [7:0]             sh_tx,
   input  logic                   sh_done,
   input  logic [7:0]             sh_rx
);
   seq_state_e  state_q;
   logic [1:0]  idx_q;
   logic [1:0]  last_q;
   logic        we_q;
   logic [31:0] wdata_q;
   logic [31:0] rdata_q;
   logic        is_user;

   assign is_user = (mode[mem_sel] == MODE_USER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         idx_q   <= '0;
         last_q  <= '0;
         we_q    <= 1'b0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         case (state_q)
            SQ_IDLE: if (mem_req) begin
               we_q    <= mem_we;
               last_q  <= mem_len;
               wdata_q <= mem_wdata;
               idx_q   <= '0;
               rdata_q <= '0;
               if (!is_user) begin
                  if (!mem_we) rdata_q <= '1;
                  state_q <= SQ_DONE;
               end else if (mem_we && !wen[mem_sel]) begin
                  state_q <= SQ_DONE;
               end else begin
                  state_q <= SQ_LAUNCH;
               end
            end
            SQ_LAUNCH: state_q <= SQ_WAIT;
            SQ_WAIT: if (sh_done) begin
               if (!we_q) rdata_q[{idx_q, 3'b000} +: 8] <= sh_rx;
               if (idx_q == last_q) begin
                  state_q <= SQ_DONE;
               end else begin
                  idx_q   <= idx_q + 2'd1;
                  state_q <= SQ_LAUNCH;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign sh_start  = (state_q == SQ_LAUNCH);
   assign sh_tx     = we_q ? wdata_q[{idx_q, 3'b000} +: 8] : 8'h00;
   assign mem_ready = (state_q == SQ_DONE);
   assign mem_rdata = rdata_q;

   // R8
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ready |=> !mem_ready);
   // R7
   gated_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_IDLE && mem_req && !is_user) |=> (mem_ready && !sh_start));
endmodule

// File: rtl/spi_win_bridge.sv
module spi_win_bridge
   import spiw_pkg::*;
#(
   parameter int NUM_CS  = 2,
   parameter int CLK_DIV = 2,
   parameter int ADDR_W  = 4,
   localparam int CS_W   = $clog2(NUM_CS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              mem_req,
   input  logic              mem_we,
   input  logic [CS_W-1:0]   mem_sel,
   input  logic [1:0]        mem_len,
   input  logic [31:0]       mem_wdata,
   output logic [31:0]       mem_rdata,
   output logic              mem_ready,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic [NUM_CS-1:0] spi_cs_n
);
   if (NUM_CS < 2 || NUM_CS > 8 || (NUM_CS & (NUM_CS - 1)) != 0) begin : g_bad_cs
      $error("NUM_CS must be 2, 4 or 8");
   end
   if (CLK_DIV < 1) begin : g_bad_div
      $error("CLK_DIV must be at least 1");
   end
   if (CTRL_BASE + NUM_CS > (1 << ADDR_W)) begin : g_bad_aw
      $error("ADDR_W too small for the control words");
   end

   logic [NUM_CS-1:0]      wen;
   logic [NUM_CS-1:0][1:0] mode;
   logic                   sh_start, sh_done, sh_busy;
   logic [7:0]             sh_tx, sh_rx;

   spiw_regs #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .wen(wen), .mode(mode),
      .cs_n(spi_cs_n)
   );

   spiw_seq #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
      .mem_sel(mem_sel), .mem_len(mem_len), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready), .wen(wen), .mode(mode),
      .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx)
   );

   spiw_shift #(.CLK_DIV(CLK_DIV)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx),
      .rx_byte(sh_rx), .done(sh_done), .busy(sh_busy), .sck(spi_sck),
      .mosi(spi_mosi), .miso(spi_miso)
   );
endmodule

// File: tb/sim_spi_win_bridge.sv
module sim_spi_win_bridge;
   localparam int CLK_PERIOD = 10;
   localparam int NCS = 2;
   localparam int DIV = 3;
   localparam int AW  = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic mem_req = 1'b0, mem_we = 1'b0;
   logic [0:0] mem_sel = '0;
   logic [1:0] mem_len = '0;
   logic [31:0] mem_wdata = '0, mem_rdata;
   logic mem_ready, spi_sck, spi_mosi, spi_miso;
   logic [NCS-1:0] spi_cs_n;

   int tests = 0, fails = 0;
   int slv_cnt = 0, sck_rises = 0, s_bit = 0, hi_run = 0, hi_bad = 0;
   logic [7:0] s_tx, s_rx = '0;
   logic [7:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_win_bridge #(.NUM_CS(NCS), .CLK_DIV(DIV), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_sel(mem_sel), .mem_len(mem_len),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
      .spi_cs_n(spi_cs_n)
   );

   function automatic logic [7:0] slave_byte(input int k);
      return 8'((60 + k * 81) & 255);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // slave model: mode 0, MSB first
   initial s_tx = slave_byte(0);
   assign spi_miso = s_tx[3'(7 - s_bit)];

   always @(posedge spi_sck) begin
      s_rx = {s_rx[6:0], spi_mosi};
      sck_rises++;
   end

   // scoreboard monitor: pop expected MOSI byte on each completed byte (R9, R6)
   always @(negedge spi_sck) begin
      if (s_bit == 7) begin
         if (exp_q.size() == 0) chk("R9 unexpected MOSI byte", {24'h0, s_rx}, 32'hxxxx_xxxx);
         else chk("R9/R6 MOSI byte", {24'h0, s_rx}, {24'h0, exp_q.pop_front()});
         slv_cnt++;
         s_tx = slave_byte(slv_cnt);
         s_bit = 0;
      end else begin
         s_bit++;
      end
   end

   // SCK high-phase width monitor (R5)
   always @(negedge clk) begin
      if (spi_sck) hi_run++;
      else begin
         if (hi_run != 0 && hi_run != DIV) hi_bad++;
         hi_run = 0;
      end
   end

   task automatic reg_wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_chk(input int a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = AW'(a);
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic flash_op(input bit we, input int sel, input int n,
                           input logic [31:0] wd, input bit pass, input string tag);
      int base, r0, waited;
      logic [31:0] exp, rd;
      base = slv_cnt; r0 = sck_rises; exp = '0;
      if (pass) for (int i = 0; i < n; i++) exp_q.push_back(we ? wd[8*i +: 8] : 8'h00);
      if (!we) begin
         if (pass) for (int i = 0; i < n; i++) exp[8*i +: 8] = slave_byte(base + i);
         else exp = '1;
      end
      @(negedge clk);
      mem_req = 1'b1; mem_we = we; mem_sel = 1'(sel); mem_len = 2'(n - 1); mem_wdata = wd;
      waited = 0;
      do begin
         @(negedge clk);
         waited++;
      end while (!mem_ready && waited < 2000);
      rd = mem_rdata;
      mem_req = 1'b0;
      if (waited >= 2000) chk({tag, " R8 ready timeout"}, 32'd0, 32'd1);
      if (!we) chk({tag, " load data"}, rd, exp);
      chk({tag, " R5 SCK rising edges"}, 32'(sck_rises - r0), pass ? 32'(8 * n) : 32'd0);
      chk({tag, " scoreboard drained"}, 32'(exp_q.size()), 32'd0);
      chk({tag, " R5 SCK idle low"}, {31'd0, spi_sck}, 32'd0);
      @(negedge clk);
      chk({tag, " R8 ready single pulse"}, {31'd0, mem_ready}, 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 cs_n after reset", {30'd0, spi_cs_n}, 32'h3);
      reg_chk(2, 32'h0000_0800, "R1 status word");
      reg_chk(4, 32'h0000_0004, "R1 ctrl0 reset");
      reg_chk(5, 32'h0000_0004, "R1 ctrl1 reset");
      reg_chk(0, 32'h0, "R1 config reset");

      // R3 user mode on slave 0, R2 select pin follows stop bit
      reg_wr(4, 32'hABCD_0003);
      reg_chk(4, 32'hABCD_0003, "R3 ctrl0 readback");
      chk("R2 cs0 low, cs1 high", {30'd0, spi_cs_n}, 32'h2);

      // R7 load on slave 1 in read mode
      flash_op(1'b0, 1, 4, 32'h0, 1'b0, "R7 non-user load");
      // R6 loads of several sizes on slave 0
      flash_op(1'b0, 0, 4, 32'h0, 1'b1, "R6 load 4B");
      flash_op(1'b0, 0, 1, 32'h0, 1'b1, "R6 load 1B");
      flash_op(1'b0, 0, 3, 32'h0, 1'b1, "R6 load 3B");
      // R4 store with enable clear
      flash_op(1'b1, 0, 2, 32'h0000_BEEF, 1'b0, "R4 store disabled");
      reg_wr(0, 32'h0001_0000);
      reg_chk(0, 32'h0001_0000, "R3 config readback");
      flash_op(1'b1, 0, 2, 32'h0000_BEEF, 1'b1, "R9 store 2B");
      flash_op(1'b1, 0, 4, 32'h1234_5678, 1'b1, "R9 store 4B");
      // R4 slave 1 still disabled even though slave 0 is enabled
      reg_wr(5, 32'h0000_0003);
      flash_op(1'b1, 1, 1, 32'h0000_0055, 1'b0, "R4 store cs1 disabled");
      // R7 store in write mode with enable set is discarded
      reg_wr(0, 32'h0003_0000);
      reg_wr(5, 32'h0000_0002);
      flash_op(1'b1, 1, 3, 32'h00C0_FFEE, 1'b0, "R7 non-user store");
      reg_wr(5, 32'h0000_0001);
      flash_op(1'b0, 1, 2, 32'h0, 1'b0, "R7 fast-read mode load");
      // R2 pins independent of each other and of traffic
      reg_wr(5, 32'h0000_0003);
      chk("R2 both selected", {30'd0, spi_cs_n}, 32'h0);
      reg_wr(4, 32'h0000_0007);
      chk("R2 cs0 released only", {30'd0, spi_cs_n}, 32'h1);
      flash_op(1'b0, 0, 2, 32'h0, 1'b1, "R2 load with stop bit set");
      chk("R2 pins unchanged by traffic", {30'd0, spi_cs_n}, 32'h1);
      flash_op(1'b1, 1, 3, 32'h00A1_B2C3, 1'b1, "R9 store 3B cs1");
      chk("R5 SCK high phase width", 32'(hi_bad), 32'd0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule